// File: doc/BRIEF.md
# Fully Associative Micro Translation Buffer

This block is a small, fully associative cache of address translations placed in front of a load/store or fetch unit. A lookup supplies a virtual address together with the tags that qualify it: a memory-space/exception-level code, a virtual-machine identifier and the address-space identifier held in the current context. One cycle later the block reports whether a live entry covers that address. On a hit it also returns the physical address, the memory type and the permission bits of that entry.

Each entry records its own page size: 4 KB, 64 KB or 2 MB. The page size decides how many virtual-address bits take part in the compare, and which low physical-address bits pass straight through from the virtual address.

New translations arrive on a fill port. The fill goes into the lowest free slot, or into a round-robin victim once every slot is in use. An invalidate port drops every entry at once, or only the entries whose address-space identifier equals a given value. Page walks, a second translation level and permission faults are handled elsewhere.

Top module: `micro_xlat_buf`

## Requirements
- R1: After reset, rsp_valid, rsp_hit and rsp_multi are 0, and every entry is invalid, so any lookup misses.
- R2: The response to a lookup that has lk_valid=1 appears on the clock edge after the request, with rsp_valid=1. In a cycle with no request, rsp_valid and rsp_hit are 0 one cycle later.
- R3: The virtual-address compare depends on the entry's fill_size code. Code 0 (4 KB) compares VA[VA_W-1:12]. Code 1 (64 KB) compares VA[VA_W-1:16]. Code 2 (2 MB) compares VA[VA_W-1:21].
- R4: On a hit, rsp_pa takes its offset bits (bits 11:0, 15:0 or 20:0, according to the page size) from lk_va, and its upper bits from the entry's physical address. On a miss, rsp_pa, rsp_mtype and rsp_perm are 0.
- R5: A hit requires the entry's space code to equal lk_space.
- R6: A hit requires the entry's ASID to equal ctx_asid.
- R7: A hit requires the entry's VMID to equal lk_vmid.
- R8: On a hit, rsp_mtype and rsp_perm carry the values that were filled into the matching entry.
- R9: When more than one entry matches, rsp_multi=1 and the data comes from the lowest-numbered matching slot.
- R10: A fill writes the lowest-numbered invalid slot when one exists.
- R11: When every slot is valid, a fill replaces the slot named by a round-robin pointer. The pointer starts at 0, moves on by one only on such fills, and wraps after slot NENT-1.
- R12: inv_all clears every entry. inv_asid_en clears only the entries whose ASID equals inv_asid. Both take effect in one cycle, so a lookup presented in the next cycle already sees the result.
- R13: When a fill and an invalidate arrive in the same cycle, the filled entry survives. Its victim is chosen from the valid bits as they stood before the invalidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_va | input | VA_W | Lookup virtual address |
| lk_space | input | SPACE_W | Memory-space / exception-level code of the request |
| lk_vmid | input | VMID_W | Virtual-machine identifier of the request |
| ctx_asid | input | ASID_W | ASID of the current context |
| fill_en | input | 1 | Write a new entry |
| fill_va | input | VA_W | Virtual address of the new entry |
| fill_pa | input | PA_W | Physical address of the new entry |
| fill_size | input | 2 | Page size code: 0=4 KB, 1=64 KB, 2=2 MB |
| fill_mtype | input | MT_W | Memory type of the new entry |
| fill_perm | input | PERM_W | Permission bits of the new entry |
| fill_asid | input | ASID_W | ASID of the new entry |
| fill_vmid | input | VMID_W | VMID of the new entry |
| fill_space | input | SPACE_W | Space code of the new entry |
| inv_all | input | 1 | Clear all entries |
| inv_asid_en | input | 1 | Clear the entries that match inv_asid |
| inv_asid | input | ASID_W | ASID selector for a selective clear |
| rsp_valid | output | 1 | Registered response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_mtype | output | MT_W | Memory type of the hit entry |
| rsp_perm | output | PERM_W | Permissions of the hit entry |

## Verification
The bench probes each page size just inside and just outside its boundary. A design that masks the wrong number of bits would hit on the neighbouring page, or would return the wrong offset bits in rsp_pa.

Space, ASID and VMID mismatches are each tried alone against an entry whose address does match. A design that skipped one of these compares would report a false hit.

An overlapping fill forces a double match. Dropping the flag, or letting the higher slot win, changes rsp_multi or rsp_pa.

The bench also fills past capacity twice and then invalidates while filling. A pointer that advanced on ordinary fills, or an invalidate that took priority over the fill, would evict the wrong page.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_2M  = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;

  // smallest page offset; stored page numbers start at this bit
  localparam int unsigned BASE_SHIFT = 12;
  // extra offset bits beyond BASE_SHIFT for the larger pages
  localparam int unsigned X64K = 4;
  localparam int unsigned X2M  = 9;
endpackage

// File: rtl/mxb_match.sv
module mxb_match
  import mxb_pkg::*;
#(
  parameter int VPN_W   = 36,
  parameter int ASID_W  = 8,
  parameter int VMID_W  = 8,
  parameter int SPACE_W = 2
) (
  input  logic               e_valid,
  input  logic [VPN_W-1:0]   e_vpn,
  input  pg_size_e           e_size,
  input  logic [ASID_W-1:0]  e_asid,
  input  logic [VMID_W-1:0]  e_vmid,
  input  logic [SPACE_W-1:0] e_space,
  input  logic [VPN_W-1:0]   q_vpn,
  input  logic [ASID_W-1:0]  q_asid,
  input  logic [VMID_W-1:0]  q_vmid,
  input  logic [SPACE_W-1:0] q_space,
  output logic               hit_o
);
  logic [VPN_W-1:0] cmp_mask;

  always_comb begin
    cmp_mask = '1;
    case (e_size)
      PG_64K:  cmp_mask[X64K-1:0] = '0;
      PG_2M:   cmp_mask[X2M-1:0]  = '0;
      default: ;
    endcase
  end

  assign hit_o = e_valid
               && (((e_vpn ^ q_vpn) & cmp_mask) == '0)
               && (e_space == q_space)
               && (e_asid == q_asid)
               && (e_vmid == q_vmid);
endmodule

// File: rtl/mxb_prio.sv
module mxb_prio #(
  parameter int NENT  = 32,
  parameter int IDX_W = $clog2(NENT)
) (
  input  logic [NENT-1:0]  hit_vec,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o,
  output logic             multi_o
);
  always_comb begin
    idx_o   = '0;
    any_o   = 1'b0;
    multi_o = 1'b0;
    for (int i = 0; i < NENT; i++) begin
      if (hit_vec[i]) begin
        if (any_o) multi_o = 1'b1;
        else       idx_o   = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mxb_victim.sv
module mxb_victim #(
  parameter int NENT  = 32,
  parameter int IDX_W = $clog2(NENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [NENT-1:0]  valid_i,
  output logic [IDX_W-1:0] victim_o,
  output logic             full_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             found;

  always_comb begin
    free_idx = '0;
    found    = 1'b0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign full_o   = !found;
  assign victim_o = found ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (fill_en && full_o)
      rr_q <= (rr_q == IDX_W'(NENT - 1)) ? '0 : rr_q + 1'b1;
  end

  // R10
  free_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !full_o) |-> !valid_i[victim_o]);

  // R11
  rr_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && full_o) |=> (rr_q != $past(rr_q)));

  // R11
  rr_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !(fill_en && full_o) |=> $stable(rr_q));
endmodule

// File: rtl/micro_xlat_buf.sv
module micro_xlat_buf
  import mxb_pkg::*;
#(
  parameter int NENT    = 32,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int ASID_W  = 8,
  parameter int VMID_W  = 8,
  parameter int SPACE_W = 2,
  parameter int MT_W    = 3,
  parameter int PERM_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [VA_W-1:0]    lk_va,
  input  logic [SPACE_W-1:0] lk_space,
  input  logic [VMID_W-1:0]  lk_vmid,
  input  logic [ASID_W-1:0]  ctx_asid,
  input  logic               fill_en,
  input  logic [VA_W-1:0]    fill_va,
  input  logic [PA_W-1:0]    fill_pa,
  input  logic [1:0]         fill_size,
  input  logic [MT_W-1:0]    fill_mtype,
  input  logic [PERM_W-1:0]  fill_perm,
  input  logic [ASID_W-1:0]  fill_asid,
  input  logic [VMID_W-1:0]  fill_vmid,
  input  logic [SPACE_W-1:0] fill_space,
  input  logic               inv_all,
  input  logic               inv_asid_en,
  input  logic [ASID_W-1:0]  inv_asid,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_multi,
  output logic [PA_W-1:0]    rsp_pa,
  output logic [MT_W-1:0]    rsp_mtype,
  output logic [PERM_W-1:0]  rsp_perm
);
  localparam int IDX_W = $clog2(NENT);
  localparam int VPN_W = VA_W - BASE_SHIFT;
  localparam int PPN_W = PA_W - BASE_SHIFT;

  // entry payload: plain arrays, written only by fill (no reset)
  logic [VPN_W-1:0]   e_vpn   [NENT];
  logic [PPN_W-1:0]   e_ppn   [NENT];
  pg_size_e           e_size  [NENT];
  logic [MT_W-1:0]    e_mt    [NENT];
  logic [PERM_W-1:0]  e_perm  [NENT];
  logic [ASID_W-1:0]  e_asid  [NENT];
  logic [VMID_W-1:0]  e_vmid  [NENT];
  logic [SPACE_W-1:0] e_space [NENT];

  logic [NENT-1:0]  valid_q, valid_nx;
  logic [NENT-1:0]  hit_vec;
  logic [IDX_W-1:0] victim, hit_idx;
  logic             tbl_full, any_hit, multi_hit;
  logic [PA_W-1:0]  pa_nx;
  logic             unused_low;

  assign unused_low = ^{fill_va[BASE_SHIFT-1:0], fill_pa[BASE_SHIFT-1:0]};

  mxb_victim #(.NENT(NENT), .IDX_W(IDX_W)) i_victim (
    .clk(clk), .rst(rst), .fill_en(fill_en), .valid_i(valid_q),
    .victim_o(victim), .full_o(tbl_full)
  );

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    mxb_match #(.VPN_W(VPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W), .SPACE_W(SPACE_W)) i_match (
      .e_valid(valid_q[g]), .e_vpn(e_vpn[g]), .e_size(e_size[g]),
      .e_asid(e_asid[g]), .e_vmid(e_vmid[g]), .e_space(e_space[g]),
      .q_vpn(lk_va[VA_W-1:BASE_SHIFT]), .q_asid(ctx_asid),
      .q_vmid(lk_vmid), .q_space(lk_space), .hit_o(hit_vec[g])
    );
  end

  mxb_prio #(.NENT(NENT), .IDX_W(IDX_W)) i_prio (
    .hit_vec(hit_vec), .idx_o(hit_idx), .any_o(any_hit), .multi_o(multi_hit)
  );

  // invalidate first, then the fill claims its slot
  always_comb begin
    valid_nx = valid_q;
    if (inv_all) valid_nx = '0;
    else if (inv_asid_en) begin
      for (int i = 0; i < NENT; i++)
        if (e_asid[i] == inv_asid) valid_nx[i] = 1'b0;
    end
    if (fill_en) valid_nx[victim] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_nx;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      e_vpn[victim]   <= fill_va[VA_W-1:BASE_SHIFT];
      e_ppn[victim]   <= fill_pa[PA_W-1:BASE_SHIFT];
      e_size[victim]  <= pg_size_e'(fill_size);
      e_mt[victim]    <= fill_mtype;
      e_perm[victim]  <= fill_perm;
      e_asid[victim]  <= fill_asid;
      e_vmid[victim]  <= fill_vmid;
      e_space[victim] <= fill_space;
    end
  end

  // physical address splice by page size of the winning entry
  always_comb begin
    pa_nx = {e_ppn[hit_idx], lk_va[BASE_SHIFT-1:0]};
    case (e_size[hit_idx])
      PG_64K:  pa_nx[BASE_SHIFT+X64K-1:BASE_SHIFT] = lk_va[BASE_SHIFT+X64K-1:BASE_SHIFT];
      PG_2M:   pa_nx[BASE_SHIFT+X2M-1:BASE_SHIFT]  = lk_va[BASE_SHIFT+X2M-1:BASE_SHIFT];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_pa    <= '0;
      rsp_mtype <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && any_hit;
      rsp_multi <= lk_valid && multi_hit;
      if (lk_valid && any_hit) begin
        rsp_pa    <= pa_nx;
        rsp_mtype <= e_mt[hit_idx];
        rsp_perm  <= e_perm[hit_idx];
      end else begin
        rsp_pa    <= '0;
        rsp_mtype <= '0;
        rsp_perm  <= '0;
      end
    end
  end

  // R1
  reset_clean_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_hit && !rsp_multi && valid_q == '0));

  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!rsp_valid && !rsp_hit));

  // R9
  multi_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> rsp_hit);

  // R12
  inv_all_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_all && !fill_en) |=> (valid_q == '0));

  // R13
  fill_survives_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> valid_q[$past(victim)]);
endmodule

// File: tb/test_micro_xlat_buf.sv
module test_micro_xlat_buf;
  localparam int NENT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_va = '0;
  logic [1:0]  lk_space = '0;
  logic [7:0]  lk_vmid = '0;
  logic [7:0]  ctx_asid = '0;
  logic        fill_en = 1'b0;
  logic [47:0] fill_va = '0;
  logic [39:0] fill_pa = '0;
  logic [1:0]  fill_size = '0;
  logic [2:0]  fill_mtype = '0;
  logic [2:0]  fill_perm = '0;
  logic [7:0]  fill_asid = '0;
  logic [7:0]  fill_vmid = '0;
  logic [1:0]  fill_space = '0;
  logic        inv_all = 1'b0;
  logic        inv_asid_en = 1'b0;
  logic [7:0]  inv_asid = '0;
  logic        rsp_valid, rsp_hit, rsp_multi;
  logic [39:0] rsp_pa;
  logic [2:0]  rsp_mtype, rsp_perm;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  micro_xlat_buf #(.NENT(NENT)) i_micro_xlat_buf (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_space(lk_space), .lk_vmid(lk_vmid), .ctx_asid(ctx_asid),
    .fill_en(fill_en), .fill_va(fill_va), .fill_pa(fill_pa),
    .fill_size(fill_size), .fill_mtype(fill_mtype), .fill_perm(fill_perm),
    .fill_asid(fill_asid), .fill_vmid(fill_vmid), .fill_space(fill_space),
    .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi),
    .rsp_pa(rsp_pa), .rsp_mtype(rsp_mtype), .rsp_perm(rsp_perm)
  );

  typedef struct packed {
    logic [47:0] va;
    logic [1:0]  sp;
    logic [7:0]  vm;
    logic [7:0]  as;
    logic        hit;
    logic [39:0] pa;
    logic [2:0]  mt;
    logic [2:0]  perm;
  } vec_t;

  // after filling the three reference entries (see main sequence)
  localparam vec_t VEC [10] = '{
    '{48'h0000_1234_5ABC, 2'd1, 8'd2, 8'd5, 1'b1, 40'h00_0ABC_DABC, 3'd3, 3'd5}, // R3 4K inside
    '{48'h0000_1234_6ABC, 2'd1, 8'd2, 8'd5, 1'b0, 40'h0,            3'd0, 3'd0}, // R3 4K next page
    '{48'h0000_4000_F123, 2'd1, 8'd2, 8'd5, 1'b1, 40'h00_8000_F123, 3'd1, 3'd2}, // R3 64K inside
    '{48'h0000_4001_0000, 2'd1, 8'd2, 8'd5, 1'b0, 40'h0,            3'd0, 3'd0}, // R3 64K outside
    '{48'h0000_7FE1_2345, 2'd0, 8'd2, 8'd7, 1'b1, 40'h00_1221_2345, 3'd2, 3'd7}, // R4 2M splice
    '{48'h0000_7FFF_FFFF, 2'd0, 8'd2, 8'd7, 1'b1, 40'h00_123F_FFFF, 3'd2, 3'd7}, // R4 2M top
    '{48'h0000_1234_5000, 2'd0, 8'd2, 8'd5, 1'b0, 40'h0,            3'd0, 3'd0}, // R5 space
    '{48'h0000_1234_5000, 2'd1, 8'd2, 8'd6, 1'b0, 40'h0,            3'd0, 3'd0}, // R6 asid
    '{48'h0000_1234_5000, 2'd1, 8'd3, 8'd5, 1'b0, 40'h0,            3'd0, 3'd0}, // R7 vmid
    '{48'h0000_8000_0000, 2'd0, 8'd2, 8'd7, 1'b0, 40'h0,            3'd0, 3'd0}  // R3 2M outside
  };
  localparam string VTAG [10] = '{"R3", "R3", "R3", "R3", "R4", "R4", "R5", "R6", "R7", "R3"};

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(input logic [47:0] va, input logic [39:0] pa, input logic [1:0] sz,
                         input logic [1:0] sp, input logic [7:0] vm, input logic [7:0] as,
                         input logic [2:0] mt, input logic [2:0] pm);
    @(negedge clk);
    fill_en = 1'b1; fill_va = va; fill_pa = pa; fill_size = sz;
    fill_space = sp; fill_vmid = vm; fill_asid = as; fill_mtype = mt; fill_perm = pm;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // response registered at the posedge between the two negedges
  task automatic do_lookup(input logic [47:0] va, input logic [1:0] sp,
                           input logic [7:0] vm, input logic [7:0] as);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_space = sp; lk_vmid = vm; ctx_asid = as;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [47:0] va, input logic [1:0] sp,
                            input logic [7:0] vm, input logic [7:0] as,
                            input logic h, input logic [39:0] pa);
    do_lookup(va, sp, vm, as);
    check(req, "hit", 64'(rsp_hit), 64'(h));
    if (h) check(req, "pa", 64'(rsp_pa), 64'(pa));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1", "rsp_hit", 64'(rsp_hit), 64'd0);
    check("R1", "rsp_multi", 64'(rsp_multi), 64'd0);
    expect_hit("R1", 48'h0, 2'd0, 8'd0, 8'd0, 1'b0, 40'h0);
    // R2 response strobe timing
    check("R2", "rsp_valid after lookup", 64'(rsp_valid), 64'd1);
    @(negedge clk);
    check("R2", "rsp_valid idle", 64'(rsp_valid), 64'd0);

    // R10 reference entries land in slots 0,1,2
    do_fill(48'h0000_1234_5000, 40'h00_0ABC_D000, 2'd0, 2'd1, 8'd2, 8'd5, 3'd3, 3'd5);
    do_fill(48'h0000_4000_0000, 40'h00_8000_0000, 2'd1, 2'd1, 8'd2, 8'd5, 3'd1, 3'd2);
    do_fill(48'h0000_7FE0_0000, 40'h00_1220_0000, 2'd2, 2'd0, 8'd2, 8'd7, 3'd2, 3'd7);

    for (int k = 0; k < 10; k++) begin
      do_lookup(VEC[k].va, VEC[k].sp, VEC[k].vm, VEC[k].as);
      check(VTAG[k], "hit", 64'(rsp_hit), 64'(VEC[k].hit));
      check("R4", "pa", 64'(rsp_pa), 64'(VEC[k].pa));
      check("R8", "mtype", 64'(rsp_mtype), 64'(VEC[k].mt));
      check("R8", "perm", 64'(rsp_perm), 64'(VEC[k].perm));
      check("R9", "multi", 64'(rsp_multi), 64'd0);
    end

    // R9 overlapping entry in slot 3, slot 0 must win
    do_fill(48'h0000_1234_5000, 40'h00_5555_5000, 2'd0, 2'd1, 8'd2, 8'd5, 3'd6, 3'd1);
    do_lookup(48'h0000_1234_5010, 2'd1, 8'd2, 8'd5);
    check("R9", "multi", 64'(rsp_multi), 64'd1);
    check("R9", "pa lowest", 64'(rsp_pa), 64'h00_0ABC_D010);

    // R12 invalidate by ASID 7 hits only the 2M entry
    @(negedge clk); inv_asid_en = 1'b1; inv_asid = 8'd7;
    @(negedge clk); inv_asid_en = 1'b0;
    expect_hit("R12", 48'h0000_7FE1_2345, 2'd0, 8'd2, 8'd7, 1'b0, 40'h0);
    expect_hit("R12", 48'h0000_4000_0004, 2'd1, 8'd2, 8'd5, 1'b1, 40'h00_8000_0004);
    // R12 invalidate all, lookup in the very next cycle
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    lk_valid = 1'b1; lk_va = 48'h0000_1234_5000; lk_space = 2'd1; lk_vmid = 8'd2; ctx_asid = 8'd5;
    @(negedge clk); lk_valid = 1'b0;
    check("R12", "hit after inv_all", 64'(rsp_hit), 64'd0);

    // R10 refill all eight slots, R11 then overflow twice
    for (int k = 0; k < NENT; k++)
      do_fill(48'h0000_0010_0000 + 48'(k) * 48'h1000, 40'h00_0200_0000 + 40'(k) * 40'h1000,
              2'd0, 2'd0, 8'd0, 8'd0, 3'd0, 3'd0);
    expect_hit("R10", 48'h0000_0010_7000, 2'd0, 8'd0, 8'd0, 1'b1, 40'h00_0200_7000);
    do_fill(48'h0000_0010_8000, 40'h00_0200_8000, 2'd0, 2'd0, 8'd0, 8'd0, 3'd0, 3'd0);
    expect_hit("R11", 48'h0000_0010_0000, 2'd0, 8'd0, 8'd0, 1'b0, 40'h0);
    expect_hit("R11", 48'h0000_0010_8000, 2'd0, 8'd0, 8'd0, 1'b1, 40'h00_0200_8000);
    do_fill(48'h0000_0010_9000, 40'h00_0200_9000, 2'd0, 2'd0, 8'd0, 8'd0, 3'd0, 3'd0);
    expect_hit("R11", 48'h0000_0010_1000, 2'd0, 8'd0, 8'd0, 1'b0, 40'h0);
    expect_hit("R11", 48'h0000_0010_2000, 2'd0, 8'd0, 8'd0, 1'b1, 40'h00_0200_2000);

    // R13 fill together with inv_all: new entry kept, rest gone
    @(negedge clk);
    inv_all = 1'b1; fill_en = 1'b1; fill_va = 48'h0000_0010_A000; fill_pa = 40'h00_0200_A000;
    fill_size = 2'd0; fill_space = 2'd0; fill_vmid = 8'd0; fill_asid = 8'd0;
    @(negedge clk);
    inv_all = 1'b0; fill_en = 1'b0;
    expect_hit("R13", 48'h0000_0010_A000, 2'd0, 8'd0, 8'd0, 1'b1, 40'h00_0200_A000);
    expect_hit("R13", 48'h0000_0010_3000, 2'd0, 8'd0, 8'd0, 1'b0, 40'h0);
    expect_hit("R13", 48'h0000_0010_9000, 2'd0, 8'd0, 8'd0, 1'b0, 40'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule